// File: doc/BRIEF.md
# Signaling Freeze Controller

This block keeps the most recent robbed-bit signaling nibble for each of the twelve channels of a T1/J1 receive path. Upstream logic extracts the signaling bits and presents each new nibble as a single-beat transfer carrying a channel number. The block writes it into a twelve-entry buffer. Software or downstream logic reads any entry combinationally by channel number.

The buffer is protected by a freeze state. Loss of signal, loss of multiframe alignment, or a single-cycle receive-slip pulse puts the block into freeze. While frozen, every entry keeps its value and incoming nibbles are dropped. The freeze is released only after the line is clean again and a full multiframe has passed with no slip. A configuration input turns automatic freezing off. A status flag shows the freeze state, and a sticky interrupt bit records each entry into freeze.

The update stream never applies back-pressure: `upd_ready` is held high, and a beat counts as transferred on every cycle in which `upd_valid` is high. A beat that arrives during freeze, or that carries an invalid channel number, is still accepted and is then discarded.

Top module: `sigfrz_top`

## Requirements
- R1: After reset, every buffer entry reads 4'hF, `frz_flag` is 0, `frz_irq` is 0, and `upd_ready` is 1.
- R2: When the block is not frozen, a beat with `upd_valid`=1 and `upd_chan` in 1..12 stores `upd_sig` into that entry. The new value is readable on `rd_sig` from the next cycle.
- R3: A beat with `upd_chan` equal to 0 or to 13..15 changes no entry. When `rd_chan` is outside 1..12, `rd_sig` reads 0.
- R4: With `auto_off`=0, `los`=1 raises `frz_flag` in the next cycle. A beat arriving in that same cycle is discarded.
- R5: With `auto_off`=0, `lomf`=1 raises `frz_flag` in the next cycle, and the flag stays high while `lomf` is held.
- R6: With `auto_off`=0, a single-cycle `slip` pulse raises `frz_flag`. The flag stays high after the pulse ends until the release condition of R8 is met.
- R7: While `frz_flag` is 1, beats are discarded and every entry holds its value.
- R8: Release happens only when all of the following occur in order:
  - a cycle with `los`, `lomf` and `slip` all low;
  - then a first `mf_sync` pulse;
  - then a second `mf_sync` pulse.

  `frz_flag` falls in the cycle after the second pulse. Any impairment in between, including a slip, restarts the sequence. A pulse in the same cycle as an impairment does not count.
- R9: While `auto_off`=1, `frz_flag` reads 0 from the next cycle on, no impairment causes a freeze, and beats update the buffer as in R2.
- R10: Each 0-to-1 transition of `frz_flag` sets `frz_irq`, together with the flag. `frz_irq` stays set until a cycle with `stat_rd`=1 clears it. If a set and a clear occur in the same cycle, the set wins. A new impairment during an existing freeze does not set `frz_irq` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_valid | input | 1 | Signaling update beat present |
| upd_ready | output | 1 | Always 1; the block never stalls the stream |
| upd_chan | input | 4 | Channel number of the beat (1..12 valid) |
| upd_sig | input | 4 | Signaling nibble of the beat |
| los | input | 1 | Loss of signal (level) |
| lomf | input | 1 | Loss of multiframe alignment (level) |
| slip | input | 1 | Receive slip (single-cycle pulse) |
| mf_sync | input | 1 | Multiframe boundary pulse |
| auto_off | input | 1 | 1 disables automatic freezing |
| rd_chan | input | 4 | Channel number to read |
| rd_sig | output | 4 | Buffered nibble of `rd_chan` (0 if out of range) |
| frz_flag | output | 1 | Freeze state |
| frz_irq | output | 1 | Sticky freeze-entry interrupt bit |
| stat_rd | input | 1 | Status read strobe; clears `frz_irq` |

## Verification
The hardest case to reach from the ports is the release path, which has several steps. Release needs a clean cycle, then two multiframe pulses, and a slip in between must throw the progress away. The stimulus first leaves the block part-way through a release with one pulse already seen. It then injects a slip, shows that the flag stays high after a further pulse, and completes the release with two more pulses. It also drives a freeze entry and a status read in the same cycle to show that the set takes priority over the clear.

// File: rtl/sigfrz_pkg.sv
package sigfrz_pkg;
  typedef enum logic [1:0] {
    FS_RUN    = 2'd0,
    FS_HOLD   = 2'd1,
    FS_WAIT_B = 2'd2,
    FS_WAIT_E = 2'd3
  } frz_state_e;
endpackage

// File: rtl/sigfrz_ctrl.sv
module sigfrz_ctrl
  import sigfrz_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic los,
  input  logic lomf,
  input  logic slip,
  input  logic mf_sync,
  input  logic auto_off,
  output logic frozen,
  output logic block_now,
  output logic frz_start
);
  frz_state_e state_q, state_d;
  logic       trig;

  assign trig = (los | lomf | slip) & ~auto_off;

  always_comb begin
    state_d = state_q;
    if (auto_off) begin
      state_d = FS_RUN;
    end else if (trig) begin
      state_d = FS_HOLD;
    end else begin
      case (state_q)
        FS_RUN:    state_d = FS_RUN;
        FS_HOLD:   state_d = FS_WAIT_B;
        FS_WAIT_B: if (mf_sync) state_d = FS_WAIT_E;
        FS_WAIT_E: if (mf_sync) state_d = FS_RUN;
        default:   state_d = FS_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= FS_RUN;
    else        state_q <= state_d;
  end

  assign frozen    = (state_q != FS_RUN);
  // same-cycle impairment blocks the beat it coincides with
  assign block_now = frozen | trig;
  assign frz_start = (state_q == FS_RUN) & trig;
endmodule

// File: rtl/sigfrz_buf.sv
module sigfrz_buf #(
  parameter int N_CH = 12,
  parameter int SW   = 4,
  parameter int CW   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CW-1:0]    wr_chan,
  input  logic [SW-1:0]    wr_data,
  input  logic [CW-1:0]    rd_chan,
  output logic [SW-1:0]    rd_data,
  output logic [N_CH*SW-1:0] flat
);
  logic [SW-1:0] ent [N_CH];

  for (genvar g = 0; g < N_CH; g++) begin : g_ent
    logic hit;
    assign hit = wr_en && (wr_chan == CW'(g + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ent[g] <= '1;
      else if (hit) ent[g] <= wr_data;
    end
    assign flat[g*SW +: SW] = ent[g];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (rd_chan == CW'(i + 1)) rd_data = ent[i];
    end
  end
endmodule

// File: rtl/sigfrz_irq.sv
module sigfrz_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_p,
  input  logic clr_p,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag <= 1'b0;
    else if (set_p) flag <= 1'b1;
    else if (clr_p) flag <= 1'b0;
  end
endmodule

// File: rtl/sigfrz_top.sv
module sigfrz_top #(
  parameter int N_CH = 12,
  parameter int SW   = 4,
  localparam int CW  = $clog2(N_CH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_valid,
  output logic          upd_ready,
  input  logic [CW-1:0] upd_chan,
  input  logic [SW-1:0] upd_sig,
  input  logic          los,
  input  logic          lomf,
  input  logic          slip,
  input  logic          mf_sync,
  input  logic          auto_off,
  input  logic [CW-1:0] rd_chan,
  output logic [SW-1:0] rd_sig,
  output logic          frz_flag,
  output logic          frz_irq,
  input  logic          stat_rd
);
  logic                 block_now;
  logic                 frz_start;
  logic                 wr_en;
  logic [N_CH*SW-1:0]   buf_flat;

  assign upd_ready = 1'b1;
  assign wr_en     = upd_valid & ~block_now;

  sigfrz_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .los       (los),
    .lomf      (lomf),
    .slip      (slip),
    .mf_sync   (mf_sync),
    .auto_off  (auto_off),
    .frozen    (frz_flag),
    .block_now (block_now),
    .frz_start (frz_start)
  );

  sigfrz_buf #(.N_CH(N_CH), .SW(SW), .CW(CW)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_chan (upd_chan),
    .wr_data (upd_sig),
    .rd_chan (rd_chan),
    .rd_data (rd_sig),
    .flat    (buf_flat)
  );

  sigfrz_irq u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set_p (frz_start),
    .clr_p (stat_rd),
    .flag  (frz_irq)
  );
endmodule

// File: rtl/sigfrz_chk.sv
module sigfrz_chk #(
  parameter int N_CH = 12,
  parameter int SW   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               los,
  input logic               lomf,
  input logic               slip,
  input logic               mf_sync,
  input logic               auto_off,
  input logic               frz_flag,
  input logic               frz_irq,
  input logic [N_CH*SW-1:0] buf_flat
);
  p_los_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (los && !auto_off) |=> frz_flag);

  p_lomf_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lomf && !auto_off) |=> frz_flag);

  p_slip_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (slip && !auto_off) |=> frz_flag);

  p_hold_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frz_flag |=> $stable(buf_flat));

  p_release_on_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frz_flag) |-> ($past(mf_sync) || $past(auto_off)));

  p_disable_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    auto_off |=> !frz_flag);

  p_irq_on_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frz_flag) |-> frz_irq);
endmodule

bind sigfrz_top sigfrz_chk #(.N_CH(N_CH), .SW(SW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .los      (los),
  .lomf     (lomf),
  .slip     (slip),
  .mf_sync  (mf_sync),
  .auto_off (auto_off),
  .frz_flag (frz_flag),
  .frz_irq  (frz_irq),
  .buf_flat (buf_flat)
);

// File: tb/sim_sigfrz_top.sv
`timescale 1ns/1ps
module sim_sigfrz_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       upd_valid = 1'b0;
  logic       upd_ready;
  logic [3:0] upd_chan = '0;
  logic [3:0] upd_sig = '0;
  logic       los = 1'b0, lomf = 1'b0, slip = 1'b0, mf_sync = 1'b0;
  logic       auto_off = 1'b0, stat_rd = 1'b0;
  logic [3:0] rd_chan = '0;
  logic [3:0] rd_sig;
  logic       frz_flag, frz_irq;

  int checks = 0;
  int fails  = 0;
  logic [3:0] model [1:12];

  always #10 clk = ~clk;

  sigfrz_top u0 (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_ready(upd_ready),
    .upd_chan(upd_chan), .upd_sig(upd_sig), .los(los), .lomf(lomf),
    .slip(slip), .mf_sync(mf_sync), .auto_off(auto_off), .rd_chan(rd_chan),
    .rd_sig(rd_sig), .frz_flag(frz_flag), .frz_irq(frz_irq), .stat_rd(stat_rd)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int ch, input int val);
    upd_valid = 1'b1; upd_chan = 4'(ch); upd_sig = 4'(val);
    step();
    upd_valid = 1'b0;
  endtask

  task automatic pulse_mf();
    mf_sync = 1'b1; step(); mf_sync = 1'b0;
  endtask

  task automatic clr_irq();
    stat_rd = 1'b1; step(); stat_rd = 1'b0;
  endtask

  task automatic chk_buf(input string req);
    for (int c = 0; c < 16; c++) begin
      rd_chan = 4'(c);
      #1;
      chk(req, int'(rd_sig), (c >= 1 && c <= 12) ? int'(model[c]) : 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 1; c <= 12; c++) model[c] = 4'hF;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk_buf("R1");
    chk("R1 frz", frz_flag, 0);
    chk("R1 irq", frz_irq, 0);
    chk("R1 ready", upd_ready, 1);

    // R2 R3 sweep all channel codes
    for (int c = 0; c < 16; c++) begin
      wr(c, (c * 7 + 2) & 15);
      if (c >= 1 && c <= 12) model[c] = 4'((c * 7 + 2) & 15);
      chk("R2 ready", upd_ready, 1);
    end
    chk_buf("R2 R3");

    // R4 los with coincident beat
    los = 1'b1; upd_valid = 1'b1; upd_chan = 4'd1; upd_sig = 4'd0;
    step();
    los = 1'b0; upd_valid = 1'b0;
    chk("R4 frz", frz_flag, 1);
    chk("R10 irq set", frz_irq, 1);
    chk_buf("R4 beat dropped");
    clr_irq();
    chk("R10 irq clr", frz_irq, 0);
    chk("R10 frz kept", frz_flag, 1);

    // R7 writes while frozen
    for (int c = 1; c <= 12; c++) wr(c, c ^ 4'hA);
    chk("R7 frz", frz_flag, 1);
    chk_buf("R7");

    // R8 release sequence with slip restart
    pulse_mf();
    chk("R8 one sync", frz_flag, 1);
    step(); step();
    slip = 1'b1; step(); slip = 1'b0;
    chk("R6 slip during freeze", frz_flag, 1);
    chk("R10 no re-raise", frz_irq, 0);
    pulse_mf();
    step(); step();
    chk("R8 after restart", frz_flag, 1);
    pulse_mf();
    chk("R8 still waiting", frz_flag, 1);
    step(); step(); step();
    pulse_mf();
    chk("R8 released", frz_flag, 0);
    wr(5, 3); model[5] = 4'd3;
    chk_buf("R2 resumes");

    // R6 slip pulse latched
    slip = 1'b1; step(); slip = 1'b0;
    for (int k = 0; k < 5; k++) step();
    chk("R6 latched", frz_flag, 1);
    chk("R10 irq slip", frz_irq, 1);
    clr_irq();
    pulse_mf(); pulse_mf();
    chk("R8 release slip", frz_flag, 0);

    // R5 lomf held
    lomf = 1'b1; step();
    chk("R5 frz", frz_flag, 1);
    pulse_mf(); pulse_mf();
    chk("R5 held", frz_flag, 1);
    lomf = 1'b0;
    pulse_mf();
    pulse_mf();
    chk("R8 sync in hold ignored", frz_flag, 1);
    pulse_mf();
    chk("R8 release lomf", frz_flag, 0);
    clr_irq();

    // R9 auto_off with impairments
    auto_off = 1'b1; los = 1'b1; lomf = 1'b1;
    wr(2, 6); model[2] = 4'd6;
    slip = 1'b1; wr(9, 1); model[9] = 4'd1; slip = 1'b0;
    chk("R9 frz", frz_flag, 0);
    chk("R9 irq", frz_irq, 0);
    chk_buf("R9");
    los = 1'b0; lomf = 1'b0; auto_off = 1'b0;
    step();
    slip = 1'b1; step(); slip = 1'b0;
    chk("R6 frz", frz_flag, 1);
    auto_off = 1'b1; step();
    chk("R9 clears", frz_flag, 0);
    auto_off = 1'b0;
    clr_irq();
    chk("R10 clr", frz_irq, 0);

    // R10 set wins over clear
    slip = 1'b1; stat_rd = 1'b1; step(); slip = 1'b0; stat_rd = 1'b0;
    chk("R10 set wins", frz_irq, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule